// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit logical address into a physical address by walking a two-level page table held in memory. Pages are 8 KB. The top ten address bits select a word in the first-level table. The next nine bits select a word in the second-level table that the first word points to. The low thirteen bits pass through unchanged as the byte offset. The block has one read port to memory and issues at most two dependent reads for each translation.

A caller presents a logical address together with the physical base of the first-level table and a length value. The length value bounds the first-level index. The walker either returns the physical address or returns a fault code. The fault code tells whether the index was out of range, the first-level word was not valid, or the second-level word was not valid. Table words are 32 bits wide. Bit 0 is the valid flag and bits 31:13 hold a frame or table number. Bits 12:1 are ignored. Every pointer found in a table is a physical address.

Top module: `pt_walker`

## Requirements
- R1: A successful walk returns paddr = {second-level word bits 31:13, logical address bits 12:0}, with fault_kind = 0.
- R2: The first read is issued at table_base + 4 * vaddr[31:22].
- R3: The second read is issued at {first-level word bits 31:13, 13'b0} + 4 * vaddr[21:13].
- R4: When vaddr[31:22] >= table_len, the walker reports fault_kind = 1 on the cycle after acceptance and issues no memory read.
- R5: A first-level word with bit 0 clear ends the walk with fault_kind = 2, and no second read is issued.
- R6: A second-level word with bit 0 clear ends the walk with fault_kind = 3.
- R7: mem_req stays high with a stable mem_addr until mem_rvalid returns, for any read latency.
- R8: req_ready is high only while idle. A request raised during a walk is ignored and does not change that walk's reads or result.
- R9: done is high for exactly one cycle per request. While done is low, fault_kind and paddr read zero.
- R10: After reset the walker is idle: req_ready = 1, done = 0, mem_req = 0.
- R11: A new request may be accepted in the same cycle that done is reported for the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request accepted this cycle if valid |
| req_vaddr | input | 32 | Logical address to translate |
| table_base | input | 32 | Physical base of the first-level table |
| table_len | input | 11 | Number of usable first-level entries |
| mem_req | output | 1 | Memory read request, held until answered |
| mem_addr | output | 32 | Memory read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data word |
| done | output | 1 | One-cycle completion pulse |
| fault_kind | output | 2 | 0 ok, 1 index out of range, 2 first level invalid, 3 second level invalid |
| paddr | output | 32 | Translated physical address |

## Verification
Completion of one walk and acceptance of the next request can happen in the same cycle, because the walker is already idle while it reports done. The bench raises a fresh request on exactly the cycle it sees done. It then checks that the old result stays intact and that the new walk issues its own reads and result. This includes a follow-on range fault, which makes done appear on two cycles in a row. Memory latency changes from walk to walk, from zero wait cycles up to three, and stray requests arrive in the middle of walks.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    typedef enum logic [1:0] {
        WS_IDLE = 2'd0,
        WS_TOP  = 2'd1,
        WS_LEAF = 2'd2
    } walk_state_e;

    typedef enum logic [1:0] {
        FK_NONE  = 2'd0,
        FK_RANGE = 2'd1,
        FK_TOP   = 2'd2,
        FK_LEAF  = 2'd3
    } fault_kind_e;
endpackage

// File: rtl/ptw_field_split.sv
module ptw_field_split #(
    parameter int AW    = 32,
    parameter int L1_W  = 10,
    parameter int L2_W  = 9,
    parameter int OFF_W = 13
) (
    input  logic [AW-1:0]    vaddr,
    output logic [L1_W-1:0]  dir_idx,
    output logic [L2_W-1:0]  leaf_idx,
    output logic [OFF_W-1:0] offset
);
    always_comb begin
        dir_idx  = vaddr[AW-1 -: L1_W];
        leaf_idx = vaddr[OFF_W +: L2_W];
        offset   = vaddr[OFF_W-1:0];
    end
endmodule

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr #(
    parameter int AW       = 32,
    parameter int IDX_W    = 10,
    parameter int ENT_LOG2 = 2
) (
    input  logic [AW-1:0]    base,
    input  logic [IDX_W-1:0] idx,
    output logic [AW-1:0]    addr
);
    localparam int PAD_W = AW - IDX_W - ENT_LOG2;

    always_comb begin
        addr = base + {{PAD_W{1'b0}}, idx, {ENT_LOG2{1'b0}}};
    end
endmodule

// File: rtl/ptw_entry_decode.sv
module ptw_entry_decode #(
    parameter int AW    = 32,
    parameter int OFF_W = 13
) (
    input  logic [AW-1:0]    entry,
    input  logic [OFF_W-1:0] offset,
    output logic             valid,
    output logic [AW-1:0]    ptr_base,
    output logic [AW-1:0]    phys
);
    localparam int NUM_W = AW - OFF_W;
    localparam logic [AW-1:0] NUM_MASK = {{NUM_W{1'b1}}, {OFF_W{1'b0}}};

    always_comb begin
        valid    = entry[0];
        ptr_base = entry & NUM_MASK;
        phys     = (entry & NUM_MASK) | {{NUM_W{1'b0}}, offset};
    end
endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
    parameter int AW       = 32,
    parameter int L1_W     = 10,
    parameter int L2_W     = 9,
    parameter int OFF_W    = 13,
    parameter int ENT_LOG2 = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [AW-1:0]   req_vaddr,
    input  logic [AW-1:0]   table_base,
    input  logic [L1_W:0]   table_len,
    output logic            mem_req,
    output logic [AW-1:0]   mem_addr,
    input  logic            mem_rvalid,
    input  logic [AW-1:0]   mem_rdata,
    output logic            done,
    output logic [1:0]      fault_kind,
    output logic [AW-1:0]   paddr
);
    import ptw_pkg::*;

    typedef struct packed {
        walk_state_e st;
        logic [AW-1:0] va;
        logic [AW-1:0] addr;
        logic          done;
        fault_kind_e   fault;
        logic [AW-1:0] paddr;
    } walk_regs_t;

    walk_regs_t r_q, r_d;

    logic [AW-1:0]    split_va;
    logic [L1_W-1:0]  dir_idx;
    logic [L2_W-1:0]  leaf_idx;
    logic [OFF_W-1:0] offset;
    logic [AW-1:0]    top_addr;
    logic [AW-1:0]    leaf_addr;
    logic             ent_valid;
    logic [AW-1:0]    ent_ptr;
    logic [AW-1:0]    ent_phys;
    logic             out_of_range;

    assign split_va = (r_q.st == WS_IDLE) ? req_vaddr : r_q.va;

    ptw_field_split #(.AW(AW), .L1_W(L1_W), .L2_W(L2_W), .OFF_W(OFF_W)) u_split (
        .vaddr(split_va), .dir_idx(dir_idx), .leaf_idx(leaf_idx), .offset(offset)
    );

    ptw_entry_addr #(.AW(AW), .IDX_W(L1_W), .ENT_LOG2(ENT_LOG2)) u_top_addr (
        .base(table_base), .idx(dir_idx), .addr(top_addr)
    );

    ptw_entry_decode #(.AW(AW), .OFF_W(OFF_W)) u_decode (
        .entry(mem_rdata), .offset(offset), .valid(ent_valid),
        .ptr_base(ent_ptr), .phys(ent_phys)
    );

    ptw_entry_addr #(.AW(AW), .IDX_W(L2_W), .ENT_LOG2(ENT_LOG2)) u_leaf_addr (
        .base(ent_ptr), .idx(leaf_idx), .addr(leaf_addr)
    );

    assign out_of_range = ({1'b0, dir_idx} >= table_len);

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        r_d.fault = FK_NONE;
        r_d.paddr = '0;
        unique case (r_q.st)
            WS_IDLE: begin
                if (req_valid) begin
                    r_d.va = req_vaddr;
                    if (out_of_range) begin
                        r_d.done  = 1'b1;
                        r_d.fault = FK_RANGE;
                    end else begin
                        r_d.st   = WS_TOP;
                        r_d.addr = top_addr;
                    end
                end
            end
            WS_TOP: begin
                if (mem_rvalid) begin
                    if (!ent_valid) begin
                        r_d.st    = WS_IDLE;
                        r_d.done  = 1'b1;
                        r_d.fault = FK_TOP;
                    end else begin
                        r_d.st   = WS_LEAF;
                        r_d.addr = leaf_addr;
                    end
                end
            end
            WS_LEAF: begin
                if (mem_rvalid) begin
                    r_d.st   = WS_IDLE;
                    r_d.done = 1'b1;
                    if (!ent_valid) begin
                        r_d.fault = FK_LEAF;
                    end else begin
                        r_d.paddr = ent_phys;
                    end
                end
            end
            default: r_d.st = WS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: WS_IDLE, va: '0, addr: '0, done: 1'b0,
                     fault: FK_NONE, paddr: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready  = (r_q.st == WS_IDLE);
    assign mem_req    = (r_q.st == WS_TOP) || (r_q.st == WS_LEAF);
    assign mem_addr   = r_q.addr;
    assign done       = r_q.done;
    assign fault_kind = r_q.fault;
    assign paddr      = r_q.paddr;
endmodule

// File: rtl/ptw_checker.sv
module ptw_checker #(
    parameter int AW   = 32,
    parameter int L1_W = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic [AW-1:0] req_vaddr,
    input logic [L1_W:0] table_len,
    input logic          mem_req,
    input logic [AW-1:0] mem_addr,
    input logic          mem_rvalid,
    input logic          done,
    input logic [1:0]    fault_kind,
    input logic [AW-1:0] paddr
);
    // R7: an unanswered read keeps its request and address
    assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

    // R8: no new request can be taken while memory is being read
    assert_busy_not_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !req_ready);

    // R4: range fault reported next cycle with no read
    assert_range_fault_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && ({1'b0, req_vaddr[AW-1 -: L1_W]} >= table_len))
        |=> (done && fault_kind == 2'd1 && !mem_req));

    // R9: result outputs are quiet between completions
    assert_quiet_outputs_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (fault_kind == 2'd0 && paddr == '0));

    // R11: the walker is idle whenever it reports completion
    assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (req_ready && !mem_req));
endmodule

bind pt_walker ptw_checker #(.AW(AW), .L1_W(L1_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .table_len(table_len), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .done(done),
    .fault_kind(fault_kind), .paddr(paddr)
);

// File: tb/tb_pt_walker.sv
module tb_pt_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [31:0] table_base = 32'h0010_0000;
    logic [10:0] table_len = 11'd700;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        done;
    logic [1:0]  fault_kind;
    logic [31:0] paddr;

    int n_chk = 0;
    int n_bad = 0;
    int lat = 0;
    int cnt = 0;
    int top_reads = 0;
    int leaf_reads = 0;
    logic [31:0] last_top = '0;
    logic [31:0] last_leaf = '0;

    always #5 clk = ~clk;

    pt_walker dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .table_base(table_base), .table_len(table_len),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .done(done), .fault_kind(fault_kind), .paddr(paddr)
    );

    function automatic logic [18:0] frame_of(int i, int j);
        int v;
        v = (i * 512 + j) * 3 + 11;
        return v[18:0];
    endfunction

    function automatic logic [31:0] mem_word(logic [31:0] a);
        logic [31:0] off;
        int i;
        int j;
        if (!a[31]) begin
            off = (a - table_base) >> 2;
            i = int'(off[9:0]);
            return {9'h100, off[9:0], 12'h3C3, (i % 3) != 0};
        end
        i = int'(a[22:13]);
        j = int'(a[10:2]);
        return {frame_of(i, j), 12'hA5A, ((i + j) % 5) != 0};
    endfunction

    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        if (mem_req && !mem_rvalid) begin
            if (cnt >= lat) begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= mem_word(mem_addr);
                cnt <= 0;
                if (mem_addr[31]) begin
                    leaf_reads <= leaf_reads + 1;
                    last_leaf  <= mem_addr;
                end else begin
                    top_reads <= top_reads + 1;
                    last_top  <= mem_addr;
                end
            end else begin
                cnt <= cnt + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic start_req(input logic [31:0] va, input bit stray);
        top_reads = 0;
        leaf_reads = 0;
        lat = (int'(va[31:22]) + int'(va[21:13])) % 4;
        chk(req_ready == 1'b1, "R11 ready at issue", {31'b0, req_ready}, 32'd1);
        req_vaddr = va;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (stray && !done) begin
            req_vaddr = va ^ 32'hFFC0_0000;
            req_valid = 1'b1;
            chk(req_ready == 1'b0, "R8 busy not ready", {31'b0, req_ready}, 32'd0);
            @(negedge clk);
            req_valid = 1'b0;
            req_vaddr = va;
        end
    endtask

    task automatic wait_done();
        int k;
        k = 0;
        while (!done && k < 60) begin
            @(negedge clk);
            k++;
        end
        if (!done) chk(1'b0, "R9 done missing", 32'd0, 32'd1);
    endtask

    task automatic judge(input logic [31:0] va);
        int i;
        int j;
        logic [1:0] ek;
        logic [31:0] ep;
        i = int'(va[31:22]);
        j = int'(va[21:13]);
        ep = '0;
        if (i >= int'(table_len)) ek = 2'd1;
        else if (i % 3 == 0) ek = 2'd2;
        else if ((i + j) % 5 == 0) ek = 2'd3;
        else begin
            ek = 2'd0;
            ep = {frame_of(i, j), va[12:0]};
        end
        case (ek)
            2'd1: begin
                chk(fault_kind == 2'd1, "R4 range fault", {30'b0, fault_kind}, 32'd1);
                chk(top_reads + leaf_reads == 0, "R4 no read", top_reads + leaf_reads, 32'd0);
            end
            2'd2: begin
                chk(fault_kind == 2'd2, "R5 top fault", {30'b0, fault_kind}, 32'd2);
                chk(leaf_reads == 0, "R5 no second read", leaf_reads, 32'd0);
            end
            2'd3: chk(fault_kind == 2'd3, "R6 leaf fault", {30'b0, fault_kind}, 32'd3);
            default: begin
                chk(fault_kind == 2'd0, "R1 fault code", {30'b0, fault_kind}, 32'd0);
                chk(paddr == ep, "R1 paddr", paddr, ep);
            end
        endcase
        if (ek != 2'd1) begin
            chk(top_reads == 1 && last_top == table_base + 32'(i * 4), "R2 top address",
                last_top, table_base + 32'(i * 4));
        end
        if (ek == 2'd0 || ek == 2'd3) begin
            chk(leaf_reads == 1 && last_leaf == (32'h8000_0000 | 32'(i << 13) | 32'(j << 2)),
                "R3 leaf address", last_leaf, 32'h8000_0000 | 32'(i << 13) | 32'(j << 2));
        end
        if (ek != 2'd0) chk(paddr == '0, "R9 paddr zero on fault", paddr, 32'd0);
    endtask

    task automatic walk(input logic [31:0] va, input bit stray);
        start_req(va, stray);
        wait_done();
        judge(va);
        @(negedge clk);
        chk(done == 1'b0, "R9 single pulse", {31'b0, done}, 32'd0);
    endtask

    function automatic logic [31:0] mk_va(int i, int j, int o);
        return {10'(i), 9'(j), 13'(o)};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R10 ready in reset", {31'b0, req_ready}, 32'd1);
        chk(done == 1'b0 && mem_req == 1'b0, "R10 quiet in reset", {30'b0, done, mem_req}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && !done && !mem_req, "R10 idle after reset",
            {29'b0, req_ready, done, mem_req}, 32'd4);

        // first-level sweep across every index, len 700
        for (int i = 0; i < 1024; i++) begin
            walk(mk_va(i, (i * 37) % 512, (i * 123 + 7) % 8192), (i % 50) == 1);
        end

        // second-level sweep across every index of one table
        table_len = 11'd1024;
        for (int j = 0; j < 512; j++) begin
            walk(mk_va(4, j, (j * 29) % 8192), (j % 64) == 3);
        end

        // length boundaries
        table_len = 11'd0;
        walk(mk_va(0, 1, 5), 1'b0);
        table_len = 11'd1;
        walk(mk_va(0, 1, 5), 1'b0);
        walk(mk_va(1, 1, 5), 1'b0);
        table_len = 11'd700;
        walk(mk_va(699, 2, 8191), 1'b0);
        walk(mk_va(700, 2, 8191), 1'b0);
        table_len = 11'd1024;
        walk(mk_va(1022, 3, 1), 1'b0);
        walk(mk_va(1023, 3, 1), 1'b0);

        // moved first-level table
        table_base = 32'h0023_4000;
        for (int i = 1; i < 40; i += 3) begin
            walk(mk_va(i, i + 2, i * 100), 1'b0);
        end

        // back-to-back: new request in the done cycle (R11)
        table_len = 11'd600;
        for (int p = 0; p < 12; p++) begin
            logic [31:0] va_a;
            logic [31:0] va_b;
            va_a = mk_va(p * 7 + 1, p * 11, p * 5);
            va_b = (p % 3 == 2) ? mk_va(900, p, p) : mk_va(p * 13 + 2, p * 3 + 1, p * 17);
            start_req(va_a, 1'b0);
            wait_done();
            judge(va_a);
            chk(req_ready == 1'b1, "R11 ready during done", {31'b0, req_ready}, 32'd1);
            start_req(va_b, 1'b0);
            wait_done();
            judge(va_b);
            @(negedge clk);
            chk(done == 1'b0, "R9 single pulse after pair", {31'b0, done}, 32'd0);
        end

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule